// File: doc/BRIEF.md
# Ternary Adder With Condition Codes

This block is a purely combinational adder and subtractor for 9-trit words in 3's-complement form. It takes a destination word, a source word, a two-bit operation select and an incoming carry trit. It returns the 9-trit sum or difference together with three condition trits: a sign trit, an overflow trit and a carry trit. A datapath that fetches operands and writes results back uses these trits to set its flags.

Each trit is carried on two wires with this code: 00 is 0, 01 is 1 and 10 is 2. The code 11 is illegal. Trit k of a word sits in bits [2k+1:2k], so trit 0 is the least significant trit. Read as unsigned, a word holds a value from 0 to 19682. Read as signed, the values 0 to 9841 are non-negative, and the values 9842 to 19682 stand for −9841 to −1.

Subtraction feeds the adder with the trit-wise complement of the source, where each trit t becomes 2 − t, and adds a carry-in of one. The carry trit that comes out of a subtraction therefore reads as "no borrow".

Top module: `tern_alu_cc`

## Requirements
- R1: With op_i = 00 (add), res_o equals (dst + src) mod 19683. c_o is 01 when dst + src ≥ 19683 and 00 otherwise.
- R2: With op_i = 01 (subtract), the block computes dst + (19682 − src) + 1. res_o is that total mod 19683. c_o is 01 when dst ≥ src as unsigned values (no borrow) and 00 when a borrow occurs.
- R3: With op_i = 10 (add with carry), the block computes dst + src + k. Here k is 1 when cin_i is 01 or 10, and k is 0 when cin_i is 00. res_o and c_o follow the rule of R1 applied to that total.
- R4: With op_i = 11 (subtract with borrow), the block computes dst + (19682 − src) + k, with k as in R3. res_o and c_o follow the rule of R1 applied to that total.
- R5: s_o is 00 when the result is zero, 01 when the result is non-zero and signed non-negative (at most 9841), and 10 when the result is signed negative (above 9841).
- R6: Overflow is judged on the two words fed to the adder: dst, and either src or its complement. v_o is 01 when both words have the same signed sign and the result's signed sign differs from it. Otherwise v_o is 00. When v_o is 01, s_o is never 00.
- R7: c_o is never 10 and never 11, for any legal input.
- R8: If any trit of dst_i, src_i or cin_i carries the code 11, err_o is 1 and res_o, s_o, v_o and c_o are all zero. With all inputs legal, err_o is 0.
- R9: For add and subtract, cin_i has no effect: all outputs are the same for every legal cin_i value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dst_i | input | 18 | Destination word, 9 trits of 2 bits each |
| src_i | input | 18 | Source word, 9 trits of 2 bits each |
| op_i | input | 2 | Operation: 00 add, 01 subtract, 10 add with carry, 11 subtract with borrow |
| cin_i | input | 2 | Incoming carry trit |
| res_o | output | 18 | Result word |
| s_o | output | 2 | Sign trit |
| v_o | output | 2 | Overflow trit |
| c_o | output | 2 | Carry trit |
| err_o | output | 1 | Set when any input trit is illegal |

## Verification
Every output is combinational, so each result is due in the same cycle that its inputs are applied, with no register on the path. The bench changes the inputs just after a rising edge and reads all outputs at the next falling edge, half a period later, by which time the logic has settled. Expected values come from integer arithmetic on the decoded words, over a dense sweep of operand values. This sweep covers the zero, signed-boundary and unsigned-boundary words, all four operations and all three carry-in values.

// File: rtl/tern_pkg.sv
package tern_pkg;
  localparam int TRIT_W = 2;
  localparam logic [1:0] TRIT_0   = 2'b00;
  localparam logic [1:0] TRIT_1   = 2'b01;
  localparam logic [1:0] TRIT_2   = 2'b10;
  localparam logic [1:0] TRIT_BAD = 2'b11;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_ADDC = 2'b10,
    OP_SUBB = 2'b11
  } tern_op_e;
endpackage

// File: rtl/trit_full_add.sv
module trit_full_add
  import tern_pkg::*;
(
  input  logic [TRIT_W-1:0] a_i,
  input  logic [TRIT_W-1:0] b_i,
  input  logic              ci_i,
  output logic [TRIT_W-1:0] sum_o,
  output logic              co_o
);
  logic [2:0] total;
  logic [2:0] wrapped;

  always_comb begin
    total   = {1'b0, a_i} + {1'b0, b_i} + {2'b00, ci_i};
    wrapped = total - 3'd3;
    if (total >= 3'd3) begin
      sum_o = wrapped[1:0];
      co_o  = 1'b1;
    end else begin
      sum_o = total[1:0];
      co_o  = 1'b0;
    end
  end
endmodule

// File: rtl/tern_sign_detect.sv
module tern_sign_detect
  import tern_pkg::*;
#(
  parameter int NTRIT = 9
) (
  input  logic [NTRIT*TRIT_W-1:0] word_i,
  output logic                    neg_o
);
  logic decided;

  // Negative exactly when the word exceeds 11..1: the first trit from the
  // top that is not 1 decides; all ones is the largest non-negative value.
  always_comb begin
    neg_o   = 1'b0;
    decided = 1'b0;
    for (int i = NTRIT - 1; i >= 0; i--) begin
      if (!decided && (word_i[i*TRIT_W +: TRIT_W] != TRIT_1)) begin
        decided = 1'b1;
        neg_o   = (word_i[i*TRIT_W +: TRIT_W] == TRIT_2);
      end
    end
  end
endmodule

// File: rtl/tern_alu_cc.sv
module tern_alu_cc
  import tern_pkg::*;
#(
  parameter int NTRIT = 9
) (
  input  logic [NTRIT*TRIT_W-1:0] dst_i,
  input  logic [NTRIT*TRIT_W-1:0] src_i,
  input  logic [1:0]              op_i,
  input  logic [TRIT_W-1:0]       cin_i,
  output logic [NTRIT*TRIT_W-1:0] res_o,
  output logic [TRIT_W-1:0]       s_o,
  output logic [TRIT_W-1:0]       v_o,
  output logic [TRIT_W-1:0]       c_o,
  output logic                    err_o
);
  localparam int WORD_W = NTRIT * TRIT_W;

  tern_op_e          op;
  logic              invert_src;
  logic              carry0;
  logic [WORD_W-1:0] b_word;
  logic [WORD_W-1:0] sum_word;
  logic [NTRIT:0]    carry;
  logic [NTRIT-1:0]  bad_dst;
  logic [NTRIT-1:0]  bad_src;
  logic              any_bad;
  logic              neg_a;
  logic              neg_b;
  logic              neg_sum;
  logic              sum_zero;
  logic              overflow;

  assign op         = tern_op_e'(op_i);
  assign invert_src = (op == OP_SUB) || (op == OP_SUBB);

  always_comb begin
    unique case (op)
      OP_ADD:  carry0 = 1'b0;
      OP_SUB:  carry0 = 1'b1;
      default: carry0 = (cin_i != TRIT_0);
    endcase
  end

  assign carry[0] = carry0;

  for (genvar k = 0; k < NTRIT; k++) begin : g_trit
    logic [TRIT_W-1:0] d_t;
    logic [TRIT_W-1:0] s_t;
    assign d_t        = dst_i[k*TRIT_W +: TRIT_W];
    assign s_t        = src_i[k*TRIT_W +: TRIT_W];
    assign bad_dst[k] = (d_t == TRIT_BAD);
    assign bad_src[k] = (s_t == TRIT_BAD);
    assign b_word[k*TRIT_W +: TRIT_W] = invert_src ? (TRIT_2 - s_t) : s_t;

    trit_full_add u_fa (
      .a_i   (d_t),
      .b_i   (b_word[k*TRIT_W +: TRIT_W]),
      .ci_i  (carry[k]),
      .sum_o (sum_word[k*TRIT_W +: TRIT_W]),
      .co_o  (carry[k+1])
    );
  end

  assign any_bad = (|bad_dst) || (|bad_src) || (cin_i == TRIT_BAD);

  tern_sign_detect #(.NTRIT(NTRIT)) u_sign_a (
    .word_i (dst_i),
    .neg_o  (neg_a)
  );

  tern_sign_detect #(.NTRIT(NTRIT)) u_sign_b (
    .word_i (b_word),
    .neg_o  (neg_b)
  );

  tern_sign_detect #(.NTRIT(NTRIT)) u_sign_sum (
    .word_i (sum_word),
    .neg_o  (neg_sum)
  );

  assign sum_zero = (sum_word == '0);
  assign overflow = (neg_a == neg_b) && (neg_sum != neg_a);

  always_comb begin
    if (any_bad) begin
      res_o = '0;
      s_o   = TRIT_0;
      v_o   = TRIT_0;
      c_o   = TRIT_0;
      err_o = 1'b1;
    end else begin
      res_o = sum_word;
      s_o   = sum_zero ? TRIT_0 : (neg_sum ? TRIT_2 : TRIT_1);
      v_o   = overflow ? TRIT_1 : TRIT_0;
      c_o   = carry[NTRIT] ? TRIT_1 : TRIT_0;
      err_o = 1'b0;
    end
  end
endmodule

// File: rtl/tern_alu_cc_chk.sv
module tern_alu_cc_chk #(
  parameter int NTRIT = 9
) (
  input logic [NTRIT*2-1:0] res_o,
  input logic [1:0]         s_o,
  input logic [1:0]         v_o,
  input logic [1:0]         c_o,
  input logic               err_o
);
  always_comb begin
    if (err_o) begin
      assert_err_zero_R8 : assert ((res_o == '0) && (s_o == 2'b00) &&
                                   (v_o == 2'b00) && (c_o == 2'b00));
    end
  end

  always_comb begin
    if (!err_o) begin
      assert_sign_zero_R5 : assert ((s_o == 2'b00) == (res_o == '0));
    end
  end

  always_comb begin
    if (!err_o) begin
      assert_carry_legal_R7 : assert ((c_o == 2'b00) || (c_o == 2'b01));
    end
  end

  always_comb begin
    if (!err_o && (v_o == 2'b01)) begin
      assert_no_overflow_zero_R6 : assert (s_o != 2'b00);
    end
  end
endmodule

bind tern_alu_cc tern_alu_cc_chk #(.NTRIT(NTRIT)) u_chk (
  .res_o (res_o),
  .s_o   (s_o),
  .v_o   (v_o),
  .c_o   (c_o),
  .err_o (err_o)
);

// File: tb/tb_tern_alu_cc.sv
`timescale 1ns/1ps
module tb_tern_alu_cc;
  localparam int N   = 9;
  localparam int MOD = 19683;
  localparam int HALF_MAX = 9841;

  logic clk;
  logic [2*N-1:0] dst, src, res;
  logic [1:0] op, cin, s, v, c;
  logic err;
  int n_chk, n_bad;
  bit done;

  tern_alu_cc dut (
    .dst_i(dst), .src_i(src), .op_i(op), .cin_i(cin),
    .res_o(res), .s_o(s), .v_o(v), .c_o(c), .err_o(err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [2*N-1:0] enc(int val);
    logic [2*N-1:0] w;
    int x;
    x = val;
    for (int i = 0; i < N; i++) begin
      w[2*i +: 2] = 2'(x % 3);
      x = x / 3;
    end
    return w;
  endfunction

  function automatic int dec(logic [2*N-1:0] w);
    int x;
    x = 0;
    for (int i = N - 1; i >= 0; i--) x = x * 3 + int'(w[2*i +: 2]);
    return x;
  endfunction

  function automatic int pick(int i);
    case (i)
      0: return 0;     1: return 1;     2: return 2;     3: return 3;
      4: return 9840;  5: return 9841;  6: return 9842;  7: return 9843;
      8: return 19680; 9: return 19681; 10: return 19682; 11: return 6561;
      12: return 13122; 13: return 4920; 14: return 14762; 15: return 243;
      default: return (i * 7919 + i * i * 1237) % MOD;
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    dst = '0; src = '0; op = 2'b00; cin = 2'b00;
    @(negedge clk);
    // initial all-zero inputs: add of zeros gives all-zero outputs (R1 R5)
    check(res == '0 && s == 2'b00 && v == 2'b00 && c == 2'b00 && err == 1'b0,
          "R1 R5 zero state", dec(res), 0);

    for (int ia = 0; ia < 36; ia++) begin
      for (int ib = 0; ib < 36; ib++) begin
        for (int o = 0; o < 4; o++) begin
          for (int ci = 0; ci < 3; ci++) begin
            int a, b, bb, k, tot, er, ec, es;
            bit na, nb, nr, ev;
            string tag;
            a = pick(ia); b = pick(ib);
            bb = (o == 1 || o == 3) ? (MOD - 1 - b) : b;
            if (o == 0) k = 0;
            else if (o == 1) k = 1;
            else k = (ci != 0) ? 1 : 0;
            tot = a + bb + k;
            er = tot % MOD;
            ec = tot / MOD;
            na = a > HALF_MAX; nb = bb > HALF_MAX; nr = er > HALF_MAX;
            ev = (na == nb) && (nr != na);
            es = (er == 0) ? 0 : (nr ? 2 : 1);
            case (o)
              0: tag = "R1 R9 add";
              1: tag = "R2 R9 sub";
              2: tag = "R3 addc";
              default: tag = "R4 subb";
            endcase
            @(posedge clk);
            #0.5;
            dst = enc(a); src = enc(b); op = 2'(o); cin = 2'(ci);
            @(negedge clk);
            check(dec(res) == er, {tag, " result"}, dec(res), er);
            check(int'(c) == ec, {tag, " carry"}, int'(c), ec);
            check(int'(s) == es, "R5 sign", int'(s), es);
            check(int'(v) == int'(ev), "R6 overflow", int'(v), int'(ev));
            check(c != 2'b10 && c != 2'b11, "R7 carry range", int'(c), ec);
            check(err == 1'b0, "R8 no error", int'(err), 0);
          end
        end
      end
    end

    // illegal code in each trit of dst, src and in cin (R8)
    for (int p = 0; p < 2 * N + 1; p++) begin
      @(posedge clk);
      #0.5;
      dst = enc(pick(20 + p)); src = enc(pick(40 + p));
      op = 2'(p % 4); cin = 2'b01;
      if (p < N) dst[2*p +: 2] = 2'b11;
      else if (p < 2 * N) src[2*(p-N) +: 2] = 2'b11;
      else cin = 2'b11;
      @(negedge clk);
      check(err == 1'b1, "R8 error flag", int'(err), 1);
      check(res == '0 && s == 2'b00 && v == 2'b00 && c == 2'b00,
            "R8 zeroed outputs", dec(res), 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule